// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source side of a two-level interrupt scheme. It watches a parameterised set of interrupt inputs. Each input is wired, through two static kind pins, as a level source, a message source or an unused slot. Each source has a configuration entry that holds a target server and an eight-bit priority. The all-ones priority means the source is masked. The block keeps a small set of status bits for each source. It sends present requests, one at a time, to a downstream presenter.

The presenter answers with three kinds of event. A done strobe ends the current request. A reject hands an interrupt back. An end-of-interrupt (EOI) closes one. Reject and EOI arrive as global source numbers, and the block maps them back to a local index by subtracting a base offset. A resend scan walks every source in turn and replays any deferred delivery. When several sources are ready in the same cycle, the lowest index is presented first.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no request is raised, every source is masked (priority 0xFF) and all status is clear. The kind pins are not touched by reset, so each source keeps its kind.
- R2: A presented number equals the local index plus NUM_BASE. A reject or EOI number is mapped back by subtracting NUM_BASE. Numbers outside [NUM_BASE, NUM_BASE+N_SRC) are ignored.
- R3: A rising edge on an unmasked message input presents that source once, with its configured server, its global number and its priority.
- R4: A rising edge on a masked message input presents nothing and sets masked-pending. A configuration write that keeps the source masked leaves it pending. A write with a priority other than 0xFF clears masked-pending and presents the source once. A request never carries priority 0xFF.
- R5: A level source presents only when it is unmasked, its input is high and its sent bit is clear. Presenting sets the sent bit, so a held-high input presents only once.
- R6: A reject of a message source sets its rejected bit. On the next resend scan that bit is cleared and the source is presented again if it is unmasked. A resend with no reject outstanding presents nothing.
- R7: A reject or an EOI of a level source clears its sent bit. A later resend scan presents the source again if its input is still high.
- R8: An EOI for a message source has no effect.
- R9: A configuration write to a level source applies the level rule again, so unmasking an asserted level source presents it.
- R10: A source with neither kind pin set ignores its input, its configuration, rejects and scans, and never presents.
- R11: Only one request is outstanding at a time. The request and its fields hold steady until pres_done. When several sources are ready together, the lowest index is served first.
- R12: A resend scan visits sources in ascending index order, one per cycle, and pauses while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Interrupt inputs (level, or rising edge for message sources) |
| kind_lvl | input | N_SRC | Static: source is level-sensitive (takes precedence) |
| kind_msg | input | N_SRC | Static: source is a message source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_srv | input | SRV_W | Target server to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones = masked) |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being closed |
| resend_go | input | 1 | Start a resend scan (ignored while one runs) |
| pres_req | output | 1 | Present request outstanding |
| pres_num | output | NUM_W | Global source number of the request |
| pres_srv | output | SRV_W | Target server of the request |
| pres_prio | output | PRIO_W | Priority of the request |
| pres_done | input | 1 | Presenter has taken the request |

## Verification
Message sources are driven with single rising edges, both masked and unmasked, and then with configuration writes that either keep or lift the mask. This separates immediate delivery from deferred delivery. Level sources are held high across rejects, EOIs and resend scans. This shows whether the sent bit blocks a second present, and whether the sent bit alone clears it. Two sources firing in the same cycle, and two rejected sources replayed by one scan, expose the order in which requests are served. Rejects that carry numbers just outside the window, or numbers without the base, must leave a later scan silent.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [1:0] {KIND_NONE, KIND_LVL, KIND_MSG} src_kind_e;

  typedef struct packed {
    logic asrt;   // registered input (level state or last message sample)
    logic sent;   // level: presented and not yet closed
    logic rej;    // message: handed back by the presenter
    logic mpend;  // message: fired while masked
    logic due;    // waiting for the present engine
  } src_stat_t;
endpackage

// File: rtl/irqs_slot.sv
module irqs_slot
  import irqs_pkg::*;
#(
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_kind_e         kind,
  input  logic              src_lvl,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_srv,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              scan_hit,
  input  logic              grant,
  output logic              ready,
  output logic [SRV_W-1:0]  srv,
  output logic [PRIO_W-1:0] prio,
  output src_stat_t         stat
);
  function automatic logic is_masked(input logic [PRIO_W-1:0] p);
    return p == {PRIO_W{1'b1}};
  endfunction

  src_stat_t         nx;
  logic [SRV_W-1:0]  nx_srv;
  logic [PRIO_W-1:0] nx_prio;
  logic              is_lvl, is_msg;

  assign is_lvl = (kind == KIND_LVL);
  assign is_msg = (kind == KIND_MSG);
  assign ready  = stat.due;

  always_comb begin
    nx      = stat;
    nx_srv  = srv;
    nx_prio = prio;
    if (grant) begin
      nx.due = 1'b0;
      if (is_lvl) nx.sent = 1'b1;
    end
    if (rej_hit) begin
      if (is_msg) nx.rej  = 1'b1;
      if (is_lvl) nx.sent = 1'b0;
    end
    if (eoi_hit && is_lvl) nx.sent = 1'b0;
    nx.asrt = src_lvl;
    if (is_lvl && (src_lvl != stat.asrt)) nx.due = 1'b1;
    if (is_msg && src_lvl && !stat.asrt) begin
      if (is_masked(prio)) nx.mpend = 1'b1;
      else                 nx.due   = 1'b1;
    end
    if (cfg_hit) begin
      nx_srv  = cfg_srv;
      nx_prio = cfg_prio;
      if (is_msg && nx.mpend && !is_masked(cfg_prio)) begin
        nx.mpend = 1'b0;
        nx.due   = 1'b1;
      end
      if (is_lvl) nx.due = 1'b1;
    end
    if (scan_hit) begin
      if (is_msg && nx.rej) begin
        nx.rej = 1'b0;
        if (!is_masked(nx_prio)) nx.due = 1'b1;
      end
      if (is_lvl) nx.due = 1'b1;
    end
    if (is_lvl && !(!is_masked(nx_prio) && nx.asrt && !nx.sent)) nx.due = 1'b0;
    if (is_msg && nx.due && is_masked(nx_prio)) begin
      nx.due   = 1'b0;
      nx.mpend = 1'b1;
    end
    if (kind == KIND_NONE) nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      srv  <= '0;
      prio <= {PRIO_W{1'b1}};
    end else begin
      stat <= nx;
      srv  <= nx_srv;
      prio <= nx_prio;
    end
  end
endmodule

// File: rtl/irqs_pick.sv
module irqs_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  win,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    win = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        win    = '0;
        win[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqs_scan.sv
module irqs_scan #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stall,
  output logic [N-1:0] hit,
  output logic         active
);
  logic [IW-1:0] ptr;
  logic          step;

  assign step = active && !stall;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = step && (ptr == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        ptr    <= '0;
      end
    end else if (step) begin
      ptr <= ptr + 1'b1;
      if (ptr == IW'(N - 1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irqs_pkg::*;
#(
  parameter int              N_SRC    = 8,
  parameter int              SRV_W    = 4,
  parameter int              PRIO_W   = 8,
  parameter int              NUM_W    = 12,
  parameter logic [NUM_W-1:0] NUM_BASE = 12'h100,
  localparam int             IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [N_SRC-1:0]  kind_lvl,
  input  logic [N_SRC-1:0]  kind_msg,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_srv,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_go,
  output logic              pres_req,
  output logic [NUM_W-1:0]  pres_num,
  output logic [SRV_W-1:0]  pres_srv,
  output logic [PRIO_W-1:0] pres_prio,
  input  logic              pres_done
);
  localparam logic [NUM_W-1:0] SRC_CNT = NUM_W'(N_SRC);

  function automatic logic in_window(input logic [NUM_W-1:0] n);
    return (n >= NUM_BASE) && ((n - NUM_BASE) < SRC_CNT);
  endfunction

  function automatic logic [IDX_W-1:0] to_local(input logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_BASE);
  endfunction

  function automatic logic [NUM_W-1:0] to_global(input logic [IDX_W-1:0] i);
    return NUM_BASE + NUM_W'(i);
  endfunction

  // named internal events
  logic [N_SRC-1:0]  grant, scan_hit, ready, cfg_hit, rej_hit, eoi_hit;
  logic [N_SRC-1:0]  pick_win;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any, scan_active;
  logic [SRV_W-1:0]  s_srv  [N_SRC];
  logic [PRIO_W-1:0] s_prio [N_SRC];
  src_stat_t         s_stat [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    src_kind_e kind;
    assign kind       = kind_lvl[g] ? KIND_LVL : (kind_msg[g] ? KIND_MSG : KIND_NONE);
    assign cfg_hit[g] = cfg_we && (cfg_idx == IDX_W'(g));
    assign rej_hit[g] = rej_valid && in_window(rej_num) && (to_local(rej_num) == IDX_W'(g));
    assign eoi_hit[g] = eoi_valid && in_window(eoi_num) && (to_local(eoi_num) == IDX_W'(g));

    irqs_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .kind(kind), .src_lvl(src_in[g]),
      .cfg_hit(cfg_hit[g]), .cfg_srv(cfg_srv), .cfg_prio(cfg_prio),
      .rej_hit(rej_hit[g]), .eoi_hit(eoi_hit[g]), .scan_hit(scan_hit[g]),
      .grant(grant[g]), .ready(ready[g]), .srv(s_srv[g]), .prio(s_prio[g]),
      .stat(s_stat[g])
    );
  end

  irqs_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req(ready), .win(pick_win), .idx(pick_idx), .any(pick_any)
  );

  irqs_scan #(.N(N_SRC), .IW(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(resend_go), .stall(pres_req),
    .hit(scan_hit), .active(scan_active)
  );

  assign grant = pres_req ? '0 : pick_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_req  <= 1'b0;
      pres_num  <= '0;
      pres_srv  <= '0;
      pres_prio <= '0;
    end else if (pres_req) begin
      if (pres_done) pres_req <= 1'b0;
    end else if (pick_any) begin
      pres_req  <= 1'b1;
      pres_num  <= to_global(pick_idx);
      pres_srv  <= s_srv[pick_idx];
      pres_prio <= s_prio[pick_idx];
    end
  end
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
  parameter int               N_SRC    = 8,
  parameter int               PRIO_W   = 8,
  parameter int               NUM_W    = 12,
  parameter logic [NUM_W-1:0] NUM_BASE = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pres_req,
  input logic              pres_done,
  input logic [NUM_W-1:0]  pres_num,
  input logic [PRIO_W-1:0] pres_prio,
  input logic [N_SRC-1:0]  grant,
  input logic [N_SRC-1:0]  scan_hit
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pres_req && !pres_done |=> pres_req && $stable(pres_num) && $stable(pres_prio)); // R11
  AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> pres_req); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R11
  AST_NUM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pres_req |-> (pres_num >= NUM_BASE) && ((pres_num - NUM_BASE) < NUM_W'(N_SRC))); // R2
  AST_NO_MASKED_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    pres_req |-> pres_prio != {PRIO_W{1'b1}}); // R4
  AST_SCAN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|scan_hit) |-> !pres_req); // R12
  AST_SCAN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scan_hit)); // R12
endmodule

bind irq_source_ctrl irqs_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .NUM_BASE(NUM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pres_req(pres_req), .pres_done(pres_done),
  .pres_num(pres_num), .pres_prio(pres_prio), .grant(grant), .scan_hit(scan_hit)
);

// File: tb/irq_source_ctrl_test.sv
module irq_source_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_in = '0;
  logic [7:0]  kind_lvl = 8'hF0;
  logic [7:0]  kind_msg = 8'h0E;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_srv = '0;
  logic [7:0]  cfg_prio = '0;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend_go = 1'b0, pres_done = 1'b0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic        pres_req;
  logic [11:0] pres_num;
  logic [3:0]  pres_srv;
  logic [7:0]  pres_prio;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_source_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .kind_lvl(kind_lvl), .kind_msg(kind_msg),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_srv(cfg_srv), .cfg_prio(cfg_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_go(resend_go), .pres_req(pres_req), .pres_num(pres_num), .pres_srv(pres_srv),
    .pres_prio(pres_prio), .pres_done(pres_done)
  );

  function automatic int e_num(int i); return 256 + i; endfunction
  function automatic int e_srv(int i); return (i * 5 + 3) % 16; endfunction
  function automatic int e_pri(int i); return 16 * i + 2; endfunction
  function automatic int pack(int s, int p, int n); return (s << 20) | (p << 12) | n; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int i, input int s, input int p);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_srv = 4'(s); cfg_prio = 8'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input int i);
    src_in[i] = 1'b1;
    @(negedge clk);
    src_in[i] = 1'b0;
  endtask

  task automatic rej(input int n);
    rej_valid = 1'b1; rej_num = 12'(n);
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input int n);
    eoi_valid = 1'b1; eoi_num = 12'(n);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic resend();
    resend_go = 1'b1;
    @(negedge clk);
    resend_go = 1'b0;
  endtask

  task automatic expect_pres(input int i, input int s, input int p, input int hold, input string tag);
    int w = 0;
    int got, exp;
    while (!pres_req && w < 40) begin @(negedge clk); w++; end
    exp = pack(s, p, e_num(i));
    got = pack(int'(pres_srv), int'(pres_prio), int'(pres_num));
    chk(pres_req && got == exp, tag, pres_req ? got : -1, exp);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      got = pack(int'(pres_srv), int'(pres_prio), int'(pres_num));
      chk(pres_req && got == exp, {tag, " hold R11"}, pres_req ? got : -1, exp);
    end
    pres_done = 1'b1;
    @(negedge clk);
    pres_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      if (pres_req) seen = int'(pres_num);
      @(negedge clk);
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pres_req == 1'b0, "R1 no request in reset", int'(pres_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pres_req == 1'b0, "R1 idle after reset", int'(pres_req), 0);

    // masked message after reset: deferred
    fire(1);
    expect_quiet(12, "R1 R4 masked message silent");
    cfg(1, e_srv(1), 8'hFF);
    expect_quiet(12, "R4 masked write keeps pending");
    cfg(1, e_srv(1), e_pri(1));
    expect_pres(1, e_srv(1), e_pri(1), 0, "R4 unmask replays pending");
    expect_quiet(12, "R4 pending replayed once");

    // message sweep
    for (int i = 1; i <= 3; i++) begin
      cfg(i, e_srv(i), e_pri(i));
      fire(i);
      expect_pres(i, e_srv(i), e_pri(i), (i == 2) ? 3 : 0, "R3 message present");
      expect_quiet(6, "R3 single present per edge");
    end

    // unconfigured slot 0
    cfg(0, 5, 8'h01);
    fire(0);
    expect_quiet(10, "R10 unconfigured fire ignored");
    rej(256);
    resend();
    expect_quiet(16, "R10 unconfigured scan ignored");

    // simultaneous fires: lowest first
    src_in[3] = 1'b1; src_in[1] = 1'b1;
    @(negedge clk);
    src_in[3] = 1'b0; src_in[1] = 1'b0;
    expect_pres(1, e_srv(1), e_pri(1), 2, "R11 lowest index first");
    expect_pres(3, e_srv(3), e_pri(3), 0, "R11 second source next");

    // reject and resend order
    fire(3);
    expect_pres(3, e_srv(3), e_pri(3), 0, "R3 present before reject");
    rej(e_num(3));
    fire(2);
    expect_pres(2, e_srv(2), e_pri(2), 0, "R3 present before reject");
    rej(e_num(2));
    expect_quiet(6, "R6 reject alone does not replay");
    resend();
    expect_pres(2, e_srv(2), e_pri(2), 2, "R6 R12 scan replays index 2 first");
    expect_pres(3, e_srv(3), e_pri(3), 0, "R6 R12 scan replays index 3 after stall");
    resend();
    expect_quiet(16, "R6 rejected bit cleared by scan");

    // EOI on message: no effect
    fire(2);
    expect_pres(2, e_srv(2), e_pri(2), 0, "R8 present");
    eoi(e_num(2));
    resend();
    expect_quiet(16, "R8 message EOI no effect");

    // number window
    fire(2);
    expect_pres(2, e_srv(2), e_pri(2), 0, "R2 present");
    rej(2);
    rej(256 + 10);
    rej(255);
    resend();
    expect_quiet(16, "R2 out-of-window reject ignored");

    // level source 4
    cfg(4, e_srv(4), e_pri(4));
    src_in[4] = 1'b1;
    expect_pres(4, e_srv(4), e_pri(4), 0, "R5 level present");
    expect_quiet(8, "R5 held level presents once");
    resend();
    expect_quiet(16, "R5 sent blocks scan");
    rej(e_num(4));
    expect_quiet(6, "R7 reject alone silent");
    resend();
    expect_pres(4, e_srv(4), e_pri(4), 0, "R7 reject then scan re-presents");
    eoi(e_num(4));
    resend();
    expect_pres(4, e_srv(4), e_pri(4), 0, "R7 EOI then scan re-presents");
    src_in[4] = 1'b0;
    @(negedge clk);
    eoi(e_num(4));
    resend();
    expect_quiet(16, "R5 deasserted level silent");

    // level unmask by configuration write
    src_in[5] = 1'b1;
    expect_quiet(10, "R9 masked level silent");
    cfg(5, e_srv(5), e_pri(5));
    expect_pres(5, e_srv(5), e_pri(5), 0, "R9 write reapplies level rule");
    src_in[5] = 1'b0;
    @(negedge clk);
    eoi(e_num(5));

    // level sweep 6..7, plus scan order on levels
    for (int i = 6; i <= 7; i++) begin
      cfg(i, e_srv(i), e_pri(i));
      src_in[i] = 1'b1;
      expect_pres(i, e_srv(i), e_pri(i), 0, "R5 level sweep");
    end
    eoi(e_num(7));
    eoi(e_num(6));
    resend();
    expect_pres(6, e_srv(6), e_pri(6), 0, "R12 level scan ascending");
    expect_pres(7, e_srv(7), e_pri(7), 0, "R12 level scan ascending");
    src_in[6] = 1'b0; src_in[7] = 1'b0;
    expect_quiet(6, "R5 lowered levels silent");

    // reset clears priorities and status, kinds survive
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fire(2);
    expect_quiet(10, "R1 priorities masked after reset");
    cfg(2, e_srv(2), e_pri(2));
    expect_pres(2, e_srv(2), e_pri(2), 0, "R1 kind kept across reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule